// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers single-cycle request pulses from eleven peripheral sources into a status register. It drives one level-sensitive interrupt line toward the processor, which is meant to feed bit 10 of the processor's cause register. Each source owns one status bit. A pulse is recorded only when that source's mask bit is set at the moment the pulse arrives. A pulse that arrives while masked is discarded and is not kept pending. Software clears status bits by writing ones to them.

Software reaches the registers through a simple 32-bit register port: write strobe, read strobe, byte offset inside the window, write data and registered read data. The window is 8 bytes wide. In the system map it sits at base address 0x1F801070, and that base is decoded upstream, so the block sees only the offset. Sub-word writes are aligned by shifting the write data by the byte lane. The window size is a parameter. Word slots beyond the two registers read as all ones and ignore writes.

Top module: `irq_gather_ctrl`

## Requirements
- R1: Status bit n belongs to source n, with this numbering: 0 vertical blank, 1 graphics, 2 optical drive, 3 DMA, 4 timer 0, 5 timer 1, 6 timer 2, 7 controller/memory-card byte received, 8 serial, 9 sound, 10 lightpen/parallel.
- R2: A pulse on `req_pulse[n]` sets status bit n at the next clock edge only if mask bit n holds 1 in that cycle. A pulse that arrives while masked is lost: setting the mask bit later does not set the status bit.
- R3: A write to word offset 0 (status) clears each status bit whose aligned data bit is 1. Bits written with 0 keep their value.
- R4: A write to word offset 4 (mask) stores the low 11 aligned data bits. A mask read returns those bits in [10:0], and bits [31:11] read as 0.
- R5: During and after reset, status is 0, the mask is 0x7FF, `irq_out` is 0 and `rd_data` is 0.
- R6: `irq_out` is 1 exactly when the status register is non-zero. It changes at the same clock edge that changes status, so it falls in the cycle after the write that clears the last set bit.
- R7: The register is chosen by `ofs` with bits [1:0] ignored. Write data is shifted left by 8×`ofs[1:0]` before use, and bits shifted past bit 31 are dropped.
- R8: When a pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `rd_data` is loaded at the clock edge of a cycle with `rd_en`. It holds that value until the next read. It shows register contents from before any write made in the same cycle.
- R10: With a window wider than 8 bytes, a read of any word slot other than 0 and 4 returns 0xFFFFFFFF, and a write there changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | 11 | One-cycle request pulses, bit n from source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| ofs | input | 3 | Byte offset inside the window |
| wr_data | input | 32 | Write data, before lane alignment |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Level interrupt request to the processor |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:
- A captured pulse appears in status, and in `irq_out`, after the edge that samples it.
- A clearing write takes effect at that same edge.
- Read data appears after the edge of the read cycle.

The bench drives inputs on the falling edge. It advances its behavioural model at the rising edge and compares `rd_data` and `irq_out` shortly after that edge, in every cycle. The effect of a write therefore becomes visible either through `irq_out` in the following compare or through a read issued in a later cycle. Directed sequences cover same-cycle collisions, lost masked pulses and lane-shifted writes. A seeded random phase then follows, and a second instance with a 16-byte window covers the empty word slots.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IRQ_SOURCES = 11;

  typedef enum logic [3:0] {
    SRC_VBLANK   = 4'd0,
    SRC_GFX      = 4'd1,
    SRC_DISC     = 4'd2,
    SRC_DMA      = 4'd3,
    SRC_TMR0     = 4'd4,
    SRC_TMR1     = 4'd5,
    SRC_TMR2     = 4'd6,
    SRC_PAD_BYTE = 4'd7,
    SRC_SERIAL   = 4'd8,
    SRC_AUDIO    = 4'd9,
    SRC_LPEN_PIO = 4'd10
  } irq_src_e;

  typedef enum logic [1:0] {
    RSEL_STATUS = 2'd0,
    RSEL_MASK   = 2'd1,
    RSEL_NONE   = 2'd2
  } rsel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFS_W   = 3,
  parameter int unsigned NUM_SRC = 11
) (
  input  logic                wr_en,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_SRC-1:0]  ack_vec,
  output logic                mask_we,
  output logic [NUM_SRC-1:0]  mask_val,
  output irqc_pkg::rsel_e     rsel
);
  import irqc_pkg::*;

  localparam int unsigned WORD_W = OFS_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic [DATA_W-1:0] aligned;

  assign word_idx = ofs[OFS_W-1:2];
  // Lane alignment: byte offset times eight, upper bits fall off.
  assign aligned  = wr_data << {ofs[1:0], 3'b000};

  always_comb begin
    if (word_idx == WORD_W'(0))      rsel = RSEL_STATUS;
    else if (word_idx == WORD_W'(1)) rsel = RSEL_MASK;
    else                             rsel = RSEL_NONE;
  end

  assign ack_vec  = (wr_en && rsel == RSEL_STATUS) ? aligned[NUM_SRC-1:0] : '0;
  assign mask_we  = wr_en && (rsel == RSEL_MASK);
  assign mask_val = aligned[NUM_SRC-1:0];

endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] val,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '1;
    else if (we) mask_q <= val;
  end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] mask,
  input  logic [NUM_SRC-1:0] ack,
  output logic [NUM_SRC-1:0] status_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // A captured pulse overrides a same-cycle clear.
    assign status_d[i] = (req[i] & mask[i]) | (status_q[i] & ~ack[i]);

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= status_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |status_d;
  end
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  irqc_pkg::rsel_e    rsel,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] mask,
  output logic [DATA_W-1:0]  rd_data
);
  import irqc_pkg::*;

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0] status_word, mask_word, rd_mux;

  if (PAD_W > 0) begin : g_pad
    assign status_word = {{PAD_W{1'b0}}, status};
    assign mask_word   = {{PAD_W{1'b0}}, mask};
  end else begin : g_nopad
    assign status_word = status;
    assign mask_word   = mask;
  end

  always_comb begin
    case (rsel)
      RSEL_STATUS: rd_mux = status_word;
      RSEL_MASK:   rd_mux = mask_word;
      default:     rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl #(
  parameter int unsigned NUM_SRC   = irqc_pkg::IRQ_SOURCES,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_BYTES = 8,
  localparam int unsigned OFS_W    = $clog2(WIN_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_pulse,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] ack_vec, mask_val, mask_q, status_q;
  logic               mask_we;
  rsel_e              rsel;

  irqc_decode #(.DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_SRC(NUM_SRC)) u_decode (
    .wr_en(wr_en), .ofs(ofs), .wr_data(wr_data),
    .ack_vec(ack_vec), .mask_we(mask_we), .mask_val(mask_val), .rsel(rsel)
  );

  irqc_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .val(mask_val), .mask_q(mask_q)
  );

  irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .req(req_pulse), .mask(mask_q), .ack(ack_vec),
    .status_q(status_q), .irq_q(irq_out)
  );

  irqc_readback #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_readback (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rsel(rsel),
    .status(status_q), .mask(mask_q), .rd_data(rd_data)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFS_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_pulse,
  input logic               wr_en,
  input logic               rd_en,
  input logic [OFS_W-1:0]   ofs,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic               past_ok;
  logic [DATA_W-1:0]  shifted;
  logic [NUM_SRC-1:0] clr_bits;
  logic               mask_rd;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign shifted  = wr_data << (8 * ofs[1:0]);
  assign clr_bits = (wr_en && ofs[OFS_W-1:2] == '0) ? shifted[NUM_SRC-1:0] : '0;
  assign mask_rd  = rd_en && (ofs[OFS_W-1:2] == (OFS_W-2)'(1));

  // R2: a status bit may only rise where an unmasked pulse arrived
  p_capture_needs_mask_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((status_q & ~$past(status_q) & ~$past(req_pulse & mask_q)) == '0));

  // R3: cleared bits without a competing pulse are zero afterwards
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((status_q & $past(clr_bits & ~req_pulse)) == '0));

  // R8: an unmasked pulse always leaves its bit set
  p_req_wins_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((~status_q & $past(req_pulse & mask_q)) == '0));

  // R6: interrupt line mirrors a non-empty status
  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    irq_out == (status_q != '0));

  // R4: upper mask readback bits are zero
  p_mask_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(mask_rd)) |-> (rd_data[DATA_W-1:NUM_SRC] == '0));

  // R5: reset values
  p_reset_state_r5: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '1 && !irq_out && rd_data == '0));

  // R9: read data holds without a read strobe
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rd_en)) |-> $stable(rd_data));

endmodule

bind irq_gather_ctrl irqc_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .req_pulse(req_pulse), .wr_en(wr_en), .rd_en(rd_en),
  .ofs(ofs), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/irq_gather_ctrl_bench.sv
`timescale 1ns/1ps
module irq_gather_ctrl_bench;
  import irqc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] req = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  ofs = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  logic [10:0] w_req = '0;
  logic        w_we = 1'b0, w_re = 1'b0;
  logic [3:0]  w_ofs = '0;
  logic [31:0] w_wd = '0;
  logic [31:0] w_rd;
  logic        w_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [10:0] m_stat, m_mask;
  logic [31:0] m_rd;
  logic        m_irq;

  always #4 clk = ~clk;

  irq_gather_ctrl u_irq_gather_ctrl (
    .clk(clk), .rst(rst), .req_pulse(req), .wr_en(we), .rd_en(re),
    .ofs(ofs), .wr_data(wd), .rd_data(rd), .irq_out(irq)
  );

  irq_gather_ctrl #(.WIN_BYTES(16)) u_wide (
    .clk(clk), .rst(rst), .req_pulse(w_req), .wr_en(w_we), .rd_en(w_re),
    .ofs(w_ofs), .wr_data(w_wd), .rd_data(w_rd), .irq_out(w_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_stat = '0; m_mask = 11'h7FF; m_rd = '0; m_irq = 1'b0;
  endtask

  task automatic model_edge(input logic [10:0] r, input logic w, input logic rr,
                            input logic [2:0] o, input logic [31:0] d);
    logic [31:0] al;
    logic [10:0] clr;
    al = d << (8 * int'(o[1:0]));
    if (rr) m_rd = o[2] ? {21'b0, m_mask} : {21'b0, m_stat};
    clr = (w && !o[2]) ? al[10:0] : 11'b0;
    m_stat = (m_stat & ~clr) | (r & m_mask);
    if (w && o[2]) m_mask = al[10:0];
    m_irq = (m_stat != 0);
  endtask

  // Entered at a falling edge; returns at the next falling edge.
  task automatic step(input string tag, input logic [10:0] r, input logic w, input logic rr,
                      input logic [2:0] o, input logic [31:0] d);
    req = r; we = w; re = rr; ofs = o; wd = d;
    @(posedge clk);
    model_edge(r, w, rr, o, d);
    #1;
    check(tag, rd, m_rd);
    check(tag, {31'b0, irq}, {31'b0, m_irq});
    @(negedge clk);
    req = '0; we = 1'b0; re = 1'b0; ofs = '0; wd = '0;
  endtask

  task automatic wstep(input logic w, input logic rr, input logic [3:0] o, input logic [31:0] d);
    w_we = w; w_re = rr; w_ofs = o; w_wd = d;
    @(posedge clk); #1;
    @(negedge clk);
    w_we = 1'b0; w_re = 1'b0; w_ofs = '0; w_wd = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    check("R5", rd, 32'h0);
    check("R5", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R5: reset register contents
    step("R5", '0, 0, 1, 3'd0, '0); check("R5", rd, 32'h0);
    step("R5", '0, 0, 1, 3'd4, '0); check("R5", rd, 32'h7FF);

    // R1 with R3 and R6: each source alone, read, then clear
    for (int n = 0; n < 11; n++) begin
      step("R1", 11'(1) << n, 0, 0, 3'd0, '0);
      check("R6", {31'b0, irq}, 32'h1);
      step("R1", '0, 0, 1, 3'd0, '0);
      check("R1", rd, 32'(1) << n);
      step("R3", '0, 1, 0, 3'd0, 32'(1) << n);
      check("R6", {31'b0, irq}, 32'h0);
    end
    step("R1", 11'(1) << int'(SRC_AUDIO), 0, 0, 3'd0, '0);
    step("R1", '0, 0, 1, 3'd0, '0); check("R1", rd, 32'h200);
    step("R1", 11'(1) << int'(SRC_VBLANK), 0, 0, 3'd0, '0);
    step("R3", '0, 1, 1, 3'd0, 32'h0); check("R3", rd, 32'h201);
    step("R3", '0, 1, 1, 3'd0, 32'h200); check("R3", rd, 32'h201);
    step("R3", '0, 0, 1, 3'd0, '0); check("R3", rd, 32'h001);
    check("R6", {31'b0, irq}, 32'h1);
    step("R6", '0, 1, 0, 3'd0, 32'hFFFFFFFF);
    check("R6", {31'b0, irq}, 32'h0);

    // R2: masked pulses are lost
    step("R2", '0, 1, 0, 3'd4, 32'h005);
    step("R2", 11'h7FF, 0, 0, 3'd0, '0);
    step("R2", '0, 1, 0, 3'd4, 32'h7FF);
    step("R2", '0, 0, 1, 3'd0, '0); check("R2", rd, 32'h005);

    // R4: mask upper bits dropped
    step("R4", '0, 1, 0, 3'd4, 32'hFFFFFFFF);
    step("R4", '0, 0, 1, 3'd4, '0); check("R4", rd, 32'h7FF);
    step("R4", '0, 1, 0, 3'd4, 32'hFFFFF800);
    step("R4", '0, 0, 1, 3'd4, '0); check("R4", rd, 32'h0);
    step("R4", 11'h7FF, 0, 1, 3'd0, '0); check("R4", rd, 32'h005);

    // R7: lane-shifted writes, register picked by the word offset
    step("R7", '0, 1, 0, 3'd5, 32'h03);
    step("R7", '0, 0, 1, 3'd6, '0); check("R7", rd, 32'h300);
    step("R7", 11'h7FF, 0, 0, 3'd0, '0);
    step("R7", '0, 1, 0, 3'd1, 32'h02);
    step("R7", '0, 1, 0, 3'd3, 32'h01);
    step("R7", '0, 0, 1, 3'd2, '0); check("R7", rd, 32'h105);
    step("R7", '0, 1, 0, 3'd7, 32'h04);
    step("R7", '0, 0, 1, 3'd4, '0); check("R7", rd, 32'h0);

    // R8: pulse and clear on the same bit
    step("R8", '0, 1, 0, 3'd4, 32'h7FF);
    step("R8", '0, 1, 0, 3'd0, 32'h7FF);
    step("R8", 11'h001, 1, 0, 3'd0, 32'h001);
    step("R8", '0, 0, 1, 3'd0, '0); check("R8", rd, 32'h001);
    check("R8", {31'b0, irq}, 32'h1);

    // R9: hold without strobe, read sees pre-write contents
    step("R9", '0, 0, 1, 3'd4, '0); check("R9", rd, 32'h7FF);
    step("R9", 11'h010, 0, 0, 3'd0, '0); check("R9", rd, 32'h7FF);
    step("R9", '0, 1, 1, 3'd0, 32'h7FF); check("R9", rd, 32'h011);
    step("R9", '0, 0, 1, 3'd0, '0); check("R9", rd, 32'h0);

    // Mixed random traffic against the model
    for (int k = 0; k < 600; k++) begin
      logic [10:0] r;
      logic [31:0] d;
      r = (($urandom % 3) == 0) ? 11'($urandom) : 11'b0;
      d = $urandom;
      if (($urandom % 4) == 0) d = d & 32'h7FF;
      step("R6", r, ($urandom % 5) == 0, ($urandom % 2) == 0, 3'($urandom), d);
    end

    // R10: empty word slots in a wider window
    wstep(0, 1, 4'd8, '0);  check("R10", w_rd, 32'hFFFFFFFF);
    wstep(0, 1, 4'd13, '0); check("R10", w_rd, 32'hFFFFFFFF);
    wstep(1, 0, 4'd12, 32'h0);
    wstep(0, 1, 4'd4, '0);  check("R10", w_rd, 32'h7FF);
    w_req = 11'h002; wstep(0, 0, 4'd0, '0); w_req = '0;
    wstep(1, 0, 4'd8, 32'h7FF);
    wstep(0, 1, 4'd0, '0);  check("R10", w_rd, 32'h002);
    check("R10", {31'b0, w_irq}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule